// File: doc/BRIEF.md
# CAN Bitwise Arbitration Monitor

This block watches the arbitration field of a CAN frame. It takes the bit the local node wants to send and the bus level sampled for that bit, and decides bit by bit whether the node keeps the bus. A node that drives recessive and reads dominant has lost to a higher-priority frame. When that happens the block raises a one-cycle pulse, records which arbitration bit caused the loss, and forces the node's transmit line recessive for the rest of the frame. A node that drives dominant and reads recessive has seen a bit error, not an arbitration loss, so the block takes no action on it.

The arbitration window follows the frame format, which is latched at start-of-frame. A standard frame arbitrates over twelve bits: eleven identifier bits, then RTR. An extended frame arbitrates over thirty-two bits: eleven base identifier bits, SRR, IDE, eighteen extension bits, then RTR. Logic 0 is dominant and the bus behaves as a wired-AND. The lowest identifier therefore wins, and a data frame beats a remote request that carries the same identifier.

Top module: `can_arb_monitor`

## Requirements
- R1: After reset, still_tx_o, arb_lost_o and lost_vld_o are 0, lost_idx_o is 0, and tx_bit_o equals tx_bit_i.
- R2: A sof_i pulse starts a frame. From the next cycle still_tx_o is 1 and lost_vld_o and lost_idx_o are cleared. The format on ext_fmt_i is latched at this pulse (0 selects standard, 1 selects extended).
- R3: A sample (sample_i high) inside the window with tx_bit_i=1 and rx_bit_i=0 makes arb_lost_o high for exactly the one cycle after that sample's clock edge, and still_tx_o drops to 0.
- R4: A sample with tx_bit_i=0 and rx_bit_i=1 causes no arbitration loss.
- R5: lost_idx_o is the number of samples taken since sof_i before the losing bit, so the first arbitration bit is index 0. lost_vld_o and lost_idx_o hold this value until the next sof_i.
- R6: In a standard frame only sample indices 0 to 11 are evaluated (index 11 is RTR). A mismatch at index 12 or later causes no loss.
- R7: In an extended frame sample indices 0 to 31 are evaluated (index 11 is SRR, 12 is IDE, 31 is RTR). A loss at index 31 is reported.
- R8: While lost_vld_o is 1, tx_bit_o is 1 whatever tx_bit_i is. Otherwise tx_bit_o equals tx_bit_i.
- R9: Only the first loss in a frame is reported. Later mismatches produce no pulse and leave lost_idx_o unchanged.
- R10: A sample_i in the same cycle as sof_i is not evaluated and is not counted.
- R11: When several monitors share a wired-AND bus, exactly the node with the lowest arbitration sequence keeps still_tx_o at 1, and every other node reports the first bit where it sent 1 and the winner sent 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle strobe at the bit sample point |
| sof_i | input | 1 | One-cycle start-of-frame pulse |
| ext_fmt_i | input | 1 | Frame format: 0 standard, 1 extended |
| tx_bit_i | input | 1 | Bit the local node wants to send |
| rx_bit_i | input | 1 | Sampled bus level |
| tx_bit_o | output | 1 | Gated transmit bit sent to the bus |
| arb_lost_o | output | 1 | One-cycle pulse when arbitration is lost |
| lost_vld_o | output | 1 | A loss has been recorded in this frame |
| lost_idx_o | output | 5 | Arbitration bit index of the recorded loss |
| still_tx_o | output | 1 | Frame in progress and arbitration not lost |

## Verification
Two functions can fall in the same cycle: a frame restart and a bit evaluation. The bench raises sof_i together with a sample strobe that carries a losing bit pattern (recessive sent, dominant read). It then checks two things. No loss may be recorded for that sample. The next sample must be recorded as index 0, which shows that the coincident sample was neither evaluated nor counted. The other overlap is a second mismatch after a loss, which must leave the first capture untouched.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  localparam int unsigned STD_ARB_LEN = 12;
  localparam int unsigned EXT_ARB_LEN = 32;
  typedef enum logic {FMT_STD = 1'b0, FMT_EXT = 1'b1} frame_fmt_e;
endpackage

// File: rtl/can_arb_window.sv
module can_arb_window #(
  parameter int unsigned STD_LEN = can_arb_pkg::STD_ARB_LEN,
  parameter int unsigned EXT_LEN = can_arb_pkg::EXT_ARB_LEN,
  parameter int unsigned IDX_W   = $clog2(EXT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             sample_i,
  input  logic             ext_i,
  output logic             active_o,
  output logic             in_win_o,
  output logic             fmt_ext_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  import can_arb_pkg::*;
  localparam int unsigned CNT_W = $clog2(EXT_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  frame_fmt_e       fmt_q;
  logic [CNT_W-1:0] win_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      fmt_q    <= FMT_STD;
    end else if (sof_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      fmt_q    <= frame_fmt_e'(ext_i);
    end else if (sample_i && active_q && cnt_q < CNT_W'(EXT_LEN)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win_len   = (fmt_q == FMT_EXT) ? CNT_W'(EXT_LEN) : CNT_W'(STD_LEN);
  assign in_win_o  = active_q && (cnt_q < win_len);
  assign active_o  = active_q;
  assign fmt_ext_o = (fmt_q == FMT_EXT);
  assign bit_idx_o = cnt_q[IDX_W-1:0];

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !sof_i && in_win_o) |=> (bit_idx_o == $past(bit_idx_o) + 1'b1)); // R5
  AST_SOF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (active_o && bit_idx_o == '0)); // R2
endmodule

// File: rtl/can_arb_decide.sv
module can_arb_decide #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             eval_i,
  input  logic             tx_bit_i,
  input  logic             rx_bit_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic             lost_o,
  output logic             lost_pulse_o,
  output logic [IDX_W-1:0] lost_idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_o       <= 1'b0;
      lost_pulse_o <= 1'b0;
      lost_idx_o   <= '0;
    end else if (sof_i) begin
      lost_o       <= 1'b0;
      lost_pulse_o <= 1'b0;
      lost_idx_o   <= '0;
    end else begin
      lost_pulse_o <= 1'b0;
      // recessive sent, dominant seen: someone with higher priority is on the bus
      if (eval_i && !lost_o && tx_bit_i && !rx_bit_i) begin
        lost_o       <= 1'b1;
        lost_pulse_o <= 1'b1;
        lost_idx_o   <= bit_idx_i;
      end
    end
  end

  AST_LOSS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_pulse_o |-> ($past(tx_bit_i) && !$past(rx_bit_i) && $past(eval_i))); // R3
  AST_BITERR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !tx_bit_i && !sof_i) |=> !lost_pulse_o); // R4
  AST_SINGLE_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !sof_i) |=> !lost_pulse_o); // R9
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !sof_i) |=> ($stable(lost_idx_o) && lost_o)); // R5
endmodule

// File: rtl/can_tx_gate.sv
module can_tx_gate (
  input  logic lost_i,
  input  logic tx_bit_i,
  output logic tx_bit_o
);
  assign tx_bit_o = lost_i ? 1'b1 : tx_bit_i;
endmodule

// File: rtl/can_arb_monitor.sv
module can_arb_monitor #(
  parameter int unsigned STD_LEN = can_arb_pkg::STD_ARB_LEN,
  parameter int unsigned EXT_LEN = can_arb_pkg::EXT_ARB_LEN,
  localparam int unsigned IDX_W  = $clog2(EXT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             sof_i,
  input  logic             ext_fmt_i,
  input  logic             tx_bit_i,
  input  logic             rx_bit_i,
  output logic             tx_bit_o,
  output logic             arb_lost_o,
  output logic             lost_vld_o,
  output logic [IDX_W-1:0] lost_idx_o,
  output logic             still_tx_o
);
  logic             active, in_win, fmt_ext;
  logic [IDX_W-1:0] bit_idx;

  can_arb_window #(.STD_LEN(STD_LEN), .EXT_LEN(EXT_LEN), .IDX_W(IDX_W)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .sample_i  (sample_i),
    .ext_i     (ext_fmt_i),
    .active_o  (active),
    .in_win_o  (in_win),
    .fmt_ext_o (fmt_ext),
    .bit_idx_o (bit_idx)
  );

  can_arb_decide #(.IDX_W(IDX_W)) u_decide (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof_i),
    .eval_i       (sample_i && in_win),
    .tx_bit_i     (tx_bit_i),
    .rx_bit_i     (rx_bit_i),
    .bit_idx_i    (bit_idx),
    .lost_o       (lost_vld_o),
    .lost_pulse_o (arb_lost_o),
    .lost_idx_o   (lost_idx_o)
  );

  can_tx_gate u_gate (
    .lost_i   (lost_vld_o),
    .tx_bit_i (tx_bit_i),
    .tx_bit_o (tx_bit_o)
  );

  assign still_tx_o = active && !lost_vld_o;

  AST_TX_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_vld_o && !sof_i) |=> tx_bit_o); // R8
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> (32'(lost_idx_o) < (fmt_ext ? EXT_LEN : STD_LEN))); // R6
  AST_STILL_TX_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> !still_tx_o); // R3
endmodule

// File: tb/tb_can_arb_monitor.sv
`timescale 1ns/1ps
module tb_wired_and_bus #(parameter int unsigned N = 3) (
  input  logic [N-1:0] drv_i,
  output logic         bus_o
);
  assign bus_o = &drv_i;
endmodule

module tb_can_arb_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sample = 1'b0, sof = 1'b0, ext = 1'b0, use_bus = 1'b0, rx_drv = 1'b1;
  logic [2:0] txd = 3'b111;
  logic [2:0] txo, lost, vld, still;
  logic [4:0] idx [3];
  logic bus, rx_line;

  int checks = 0;
  int errors = 0;

  tb_wired_and_bus #(.N(3)) u_bus (.drv_i(txo), .bus_o(bus));
  assign rx_line = use_bus ? bus : rx_drv;

  can_arb_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sof_i(sof), .ext_fmt_i(ext),
    .tx_bit_i(txd[0]), .rx_bit_i(rx_line), .tx_bit_o(txo[0]), .arb_lost_o(lost[0]),
    .lost_vld_o(vld[0]), .lost_idx_o(idx[0]), .still_tx_o(still[0]));
  can_arb_monitor node1 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sof_i(sof), .ext_fmt_i(ext),
    .tx_bit_i(txd[1]), .rx_bit_i(rx_line), .tx_bit_o(txo[1]), .arb_lost_o(lost[1]),
    .lost_vld_o(vld[1]), .lost_idx_o(idx[1]), .still_tx_o(still[1]));
  can_arb_monitor node2 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sof_i(sof), .ext_fmt_i(ext),
    .tx_bit_i(txd[2]), .rx_bit_i(rx_line), .tx_bit_o(txo[2]), .arb_lost_o(lost[2]),
    .lost_vld_o(vld[2]), .lost_idx_o(idx[2]), .still_tx_o(still[2]));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_frame(input logic e);
    @(negedge clk); sof = 1'b1; ext = e; sample = 1'b0;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic send_bit(input logic t, input logic r);
    @(negedge clk); txd[0] = t; rx_drv = r; sample = 1'b1;
    @(negedge clk); sample = 1'b0;
  endtask

  function automatic logic arb_bit(input logic [28:0] id, input logic e, input logic rtr, input int i);
    if (!e) return (i < 11) ? id[10-i] : (i == 11) ? rtr : 1'b1;
    if (i < 11) return id[28-i];
    if (i == 11 || i == 12) return 1'b1;
    if (i < 31) return id[30-i];
    if (i == 31) return rtr;
    return 1'b1;
  endfunction

  task automatic t_reset();
    chk("R1", "still_tx", still[0], 0);
    chk("R1", "arb_lost", lost[0], 0);
    chk("R1", "lost_vld", vld[0], 0);
    chk("R1", "lost_idx", idx[0], 0);
    @(negedge clk); txd[0] = 1'b0; #1;
    chk("R1", "tx passthrough 0", txo[0], 0);
    txd[0] = 1'b1; #1;
    chk("R1", "tx passthrough 1", txo[0], 1);
  endtask

  task automatic t_std_loss();
    start_frame(1'b0);
    chk("R2", "still_tx after sof", still[0], 1);
    for (int i = 0; i < 5; i++) send_bit(i[0], i[0]);
    send_bit(1'b1, 1'b0);
    chk("R3", "loss pulse", lost[0], 1);
    chk("R3", "still_tx dropped", still[0], 0);
    chk("R5", "loss index", idx[0], 5);
    @(negedge clk);
    chk("R3", "pulse one cycle", lost[0], 0);
    txd[0] = 1'b0; #1;
    chk("R8", "tx forced recessive", txo[0], 1);
    send_bit(1'b1, 1'b0);
    chk("R9", "no second pulse", lost[0], 0);
    chk("R9", "index kept", idx[0], 5);
    chk("R5", "valid held", vld[0], 1);
  endtask

  task automatic t_sof_clear();
    start_frame(1'b0);
    chk("R2", "valid cleared", vld[0], 0);
    chk("R2", "index cleared", idx[0], 0);
    chk("R2", "still_tx", still[0], 1);
    @(negedge clk); txd[0] = 1'b0; #1;
    chk("R8", "tx follows input without loss", txo[0], 0);
  endtask

  task automatic t_bit_error();
    start_frame(1'b0);
    send_bit(1'b0, 1'b1);
    chk("R4", "no pulse on bit error", lost[0], 0);
    chk("R4", "still_tx on bit error", still[0], 1);
  endtask

  task automatic t_std_window();
    start_frame(1'b0);
    for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    chk("R6", "no loss past RTR", vld[0], 0);
    chk("R6", "still_tx past window", still[0], 1);
  endtask

  task automatic t_ext_window();
    start_frame(1'b1);
    for (int i = 0; i < 31; i++) send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    chk("R7", "loss at extended RTR", lost[0], 1);
    chk("R7", "index 31", idx[0], 31);
  endtask

  task automatic t_sof_collide();
    @(negedge clk); sof = 1'b1; ext = 1'b0; sample = 1'b1; txd[0] = 1'b1; rx_drv = 1'b0;
    @(negedge clk); sof = 1'b0; sample = 1'b0;
    chk("R10", "coincident sample ignored", vld[0], 0);
    send_bit(1'b1, 1'b0);
    chk("R10", "next sample is index 0", idx[0], 0);
    chk("R10", "loss recorded", vld[0], 1);
  endtask

  task automatic t_three(input logic [28:0] id0, id1, id2, input logic [2:0] rtr,
                         input logic e, input string tag);
    logic [28:0] ids [3];
    logic [31:0] key [3];
    int len, win, exp_idx;
    ids[0] = id0; ids[1] = id1; ids[2] = id2;
    len = e ? 32 : 12;
    for (int n = 0; n < 3; n++) begin
      key[n] = '0;
      for (int i = 0; i < len; i++) key[n] = {key[n][30:0], arb_bit(ids[n], e, rtr[n], i)};
    end
    win = 0;
    for (int n = 1; n < 3; n++) if (key[n] < key[win]) win = n;
    use_bus = 1'b1;
    start_frame(e);
    for (int i = 0; i < len + 3; i++) begin
      @(negedge clk);
      for (int n = 0; n < 3; n++) txd[n] = arb_bit(ids[n], e, rtr[n], i);
      sample = 1'b1;
      @(negedge clk); sample = 1'b0;
    end
    chk("R11", {tag, " winner count"}, $countones(still), 1);
    for (int n = 0; n < 3; n++) begin
      if (n == win) begin
        chk("R11", {tag, " winner completes"}, still[n], 1);
      end else begin
        exp_idx = -1;
        for (int i = len - 1; i >= 0; i--)
          if (arb_bit(ids[n], e, rtr[n], i) && !arb_bit(ids[win], e, rtr[win], i)) exp_idx = i;
        chk("R11", {tag, " loser index"}, vld[n] ? int'(idx[n]) : -1, exp_idx);
      end
    end
    use_bus = 1'b0;
    txd = 3'b111;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std_loss();
    t_sof_clear();
    t_bit_error();
    t_std_window();
    t_ext_window();
    t_sof_collide();
    t_three(29'h123, 29'h120, 29'h1F0, 3'b000, 1'b0, "std ids");
    t_three(29'h055, 29'h055, 29'h056, 3'b010, 1'b0, "data beats remote");
    t_three(29'h1ABCDE01, 29'h1ABCDE00, 29'h1ABCDF00, 3'b000, 1'b1, "ext ids");
    t_three(29'h0000_0A5, 29'h0000_0A5, 29'h1000_0000, 3'b001, 1'b1, "ext rtr");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule